// File: doc/BRIEF.md
# Associative Cache Tag Maintenance Port

This block gives software a memory-mapped window onto the tag array of a four-way set-associative data cache with 256 sets. A write whose address falls in the tag window either overwrites one chosen line (direct mode) or searches every way of the addressed set for a supplied tag (associative mode). Associative mode lets software clean or invalidate a line without knowing which way holds it.

In associative mode only a line that is valid and carries a matching tag is touched, and only its dirty and valid bits change. If a dirty line loses either bit, the block posts a write-back request. The request names the way, the set and the stored tag. A miss, an invalid match or a reported translation miss leaves the array unchanged and raises no fault. Reads in the window return the stored state of the addressed line one cycle later.

Top module: `tag_maint_port`

## Requirements
- R1: Only accesses with address bits [31:24] equal to 0xF4 reach the tag array. Writes elsewhere change nothing. Reads elsewhere leave `rdata_vld` low and `rdata` zero.
- R2: A synchronous reset clears the valid bit (bit 0) and the dirty bit (bit 1) of every line and drops `wb_req`.
- R3: A write with address bit 3 equal to 0 is a direct write. It stores tag = wdata[31:10], dirty = wdata[1] and valid = wdata[0] into the way given by address bits [14:13] and the set given by address bits [12:5].
- R4: A read in the window returns, on the next cycle with `rdata_vld` high, the addressed line as tag in [31:10], dirty in bit 1, valid in bit 0, and zero in every other bit.
- R5: A write with address bit 3 equal to 1 is associative. Address bits [14:13] are ignored. Each way of the set is compared against wdata[31:10]. A valid way with a matching tag takes the new dirty and valid bits, and its tag is kept.
- R6: An associative write that matches no valid way changes no line.
- R7: An associative write with `xlat_miss` high changes no line and raises no request.
- R8: An associative write that hits a dirty line and writes 0 to its dirty or valid bit raises `wb_req` on the next cycle, carrying that way, set and stored tag. The line update still takes place.
- R9: An associative hit on a clean line, or one that keeps both bits at 1, raises no request.
- R10: `wb_req` and its fields stay constant until `wb_ack` is high for one cycle. `wb_req` is low on the cycle after the ack.
- R11: While `wb_req` is high, every tag-array write is ignored.
- R12: If more than one valid way in a set matches, only the lowest-numbered way is updated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| addr | input | 32 | Access address |
| wdata | input | 32 | Write data word |
| xlat_miss | input | 1 | Translation of the supplied tag failed |
| rdata | output | 32 | Read data, registered |
| rdata_vld | output | 1 | Read data valid |
| wb_req | output | 1 | Write-back request pending |
| wb_way | output | 2 | Way of the line to write back |
| wb_set | output | 8 | Set of the line to write back |
| wb_tag | output | 22 | Stored tag of the line to write back |
| wb_ack | input | 1 | One-cycle acknowledge of the request |

## Verification
A wrong stored tag, dirty bit or valid bit shows up on the port in one of two ways. It appears in `rdata` one cycle after a read of that line. It can also appear as a missing or spurious `wb_req` one cycle after an associative write. Wrong way selection shows as a change to a neighbouring way or a wrong `wb_way`. A broken hold on the request shows as fields that move, or a `wb_req` that fails to drop, within a cycle of the ack.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    localparam int unsigned ADDR_W      = 32;
    localparam int unsigned DATA_W      = 32;
    localparam int unsigned REGION_LSB  = 24;
    localparam int unsigned REGION_W    = ADDR_W - REGION_LSB;
    localparam logic [REGION_W-1:0] REGION_CODE = 8'hF4;
    localparam int unsigned WAY_LSB     = 13;
    localparam int unsigned WAY_W       = 2;
    localparam int unsigned NUM_WAYS    = 1 << WAY_W;
    localparam int unsigned SET_LSB     = 5;
    localparam int unsigned SET_W       = 8;
    localparam int unsigned NUM_SETS    = 1 << SET_W;
    localparam int unsigned ASSOC_BIT   = 3;
    localparam int unsigned TAG_LSB     = 10;
    localparam int unsigned TAG_W       = DATA_W - TAG_LSB;
    localparam int unsigned DIRTY_BIT   = 1;
    localparam int unsigned VALID_BIT   = 0;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [SET_W-1:0] set_t;
    typedef logic [WAY_W-1:0] way_t;

    typedef struct packed {
        tag_t tag;
        logic dirty;
        logic valid;
    } line_t;

    typedef struct packed {
        logic wr;
        logic rd;
        logic assoc;
        way_t way;
        set_t set;
        tag_t tag;
        logic dirty;
        logic valid;
    } req_t;

    typedef struct packed {
        way_t way;
        set_t set;
        tag_t tag;
    } wb_t;

    function automatic logic [DATA_W-1:0] line_to_word(input line_t l);
        logic [DATA_W-1:0] w;
        w = '0;
        w[TAG_LSB +: TAG_W] = l.tag;
        w[DIRTY_BIT]        = l.dirty;
        w[VALID_BIT]        = l.valid;
        return w;
    endfunction

endpackage

// File: rtl/ctm_decode.sv
module ctm_decode
    import ctm_pkg::*;
(
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output req_t              req
);
    logic in_window;

    always_comb begin
        in_window = (addr[REGION_LSB +: REGION_W] == REGION_CODE);
        req.wr    = wr_en && in_window;
        req.rd    = rd_en && in_window;
        req.assoc = addr[ASSOC_BIT];
        req.way   = addr[WAY_LSB +: WAY_W];
        req.set   = addr[SET_LSB +: SET_W];
        req.tag   = wdata[TAG_LSB +: TAG_W];
        req.dirty = wdata[DIRTY_BIT];
        req.valid = wdata[VALID_BIT];
    end
endmodule

// File: rtl/ctm_way_bank.sv
module ctm_way_bank
    import ctm_pkg::*;
#(
    parameter int unsigned SETS = NUM_SETS
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  we,
    input  logic  tag_we,
    input  set_t  set_idx,
    input  line_t wline,
    output line_t rline
);
    tag_t            tag_mem [SETS];
    logic [SETS-1:0] valid_q;
    logic [SETS-1:0] dirty_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (we) begin
            valid_q[set_idx] <= wline.valid;
            dirty_q[set_idx] <= wline.dirty;
        end
    end

    always_ff @(posedge clk) begin
        if (we && tag_we) begin
            tag_mem[set_idx] <= wline.tag;
        end
    end

    always_comb begin
        rline.tag   = tag_mem[set_idx];
        rline.dirty = dirty_q[set_idx];
        rline.valid = valid_q[set_idx];
    end

    // Without a write strobe the state bits of this way must not move (R6, R7, R11).
    assert_bank_idle_stable_R6: assert property (@(posedge clk) disable iff (rst)
        !we |=> ($stable(valid_q) && $stable(dirty_q)));
endmodule

// File: rtl/ctm_match.sv
module ctm_match
    import ctm_pkg::*;
#(
    parameter int unsigned WAYS = NUM_WAYS
) (
    input  logic                 clk,
    input  logic                 rst,
    input  line_t [WAYS-1:0]     lines,
    input  tag_t                 tag_i,
    output logic                 hit,
    output way_t                 hit_way
);
    logic [WAYS-1:0] match_vec;

    for (genvar w = 0; w < WAYS; w++) begin : g_cmp
        assign match_vec[w] = lines[w].valid && (lines[w].tag == tag_i);
    end

    always_comb begin
        hit_way = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit_way = way_t'(i);
            end
        end
        hit = |match_vec;
    end

    // The selected way must be valid and hold the supplied tag (R5).
    assert_hit_line_valid_R5: assert property (@(posedge clk) disable iff (rst)
        hit |-> (lines[hit_way].valid && (lines[hit_way].tag == tag_i)));

    // No lower-numbered way may also match the selected one (R12).
    assert_lowest_way_R12: assert property (@(posedge clk) disable iff (rst)
        (hit && hit_way != '0) |-> !(lines[0].valid && lines[0].tag == tag_i));
endmodule

// File: rtl/tag_maint_port.sv
module tag_maint_port
    import ctm_pkg::*;
#(
    parameter int unsigned WAYS = NUM_WAYS,
    parameter int unsigned SETS = NUM_SETS
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              xlat_miss,
    output logic [DATA_W-1:0] rdata,
    output logic              rdata_vld,
    output logic              wb_req,
    output logic [WAY_W-1:0]  wb_way,
    output logic [SET_W-1:0]  wb_set,
    output logic [TAG_W-1:0]  wb_tag,
    input  logic              wb_ack
);
    req_t             req;
    line_t [WAYS-1:0] rlines;
    logic             hit;
    way_t             hit_way;
    logic             do_direct;
    logic             do_assoc;
    logic             need_wb;
    line_t            wline;
    logic [WAYS-1:0]  way_we;
    wb_t              wb_q;
    logic             pend_q;

    ctm_decode u_decode (
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .req   (req)
    );

    ctm_match #(.WAYS(WAYS)) u_match (
        .clk     (clk),
        .rst     (rst),
        .lines   (rlines),
        .tag_i   (req.tag),
        .hit     (hit),
        .hit_way (hit_way)
    );

    always_comb begin
        do_direct   = req.wr && !req.assoc && !pend_q;
        do_assoc    = req.wr && req.assoc && !xlat_miss && hit && !pend_q;
        need_wb     = do_assoc && rlines[hit_way].dirty && (!req.dirty || !req.valid);
        wline.tag   = req.tag;
        wline.dirty = req.dirty;
        wline.valid = req.valid;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        assign way_we[w] = (do_direct && req.way == way_t'(w))
                        || (do_assoc && hit_way == way_t'(w));

        ctm_way_bank #(.SETS(SETS)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .we      (way_we[w]),
            .tag_we  (do_direct),
            .set_idx (req.set),
            .wline   (wline),
            .rline   (rlines[w])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q <= 1'b0;
            wb_q   <= '0;
        end else if (need_wb) begin
            pend_q      <= 1'b1;
            wb_q.way    <= hit_way;
            wb_q.set    <= req.set;
            wb_q.tag    <= rlines[hit_way].tag;
        end else if (wb_ack) begin
            pend_q <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata     <= '0;
            rdata_vld <= 1'b0;
        end else begin
            rdata_vld <= req.rd;
            rdata     <= req.rd ? line_to_word(rlines[req.way]) : '0;
        end
    end

    assign wb_req = pend_q;
    assign wb_way = wb_q.way;
    assign wb_set = wb_q.set;
    assign wb_tag = wb_q.tag;

    assert_wb_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wb_req && !wb_ack) |=> (wb_req && $stable(wb_way) && $stable(wb_set) && $stable(wb_tag)));

    assert_wb_drop_R10: assert property (@(posedge clk) disable iff (rst)
        (wb_req && wb_ack) |=> !wb_req);

    assert_wb_cause_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(wb_req) |-> $past(wr_en && addr[ASSOC_BIT] && !xlat_miss
                                && addr[REGION_LSB +: REGION_W] == REGION_CODE));

    assert_rd_window_R1: assert property (@(posedge clk) disable iff (rst)
        rdata_vld |-> $past(rd_en && addr[REGION_LSB +: REGION_W] == REGION_CODE));

    assert_rd_zero_R4: assert property (@(posedge clk) disable iff (rst)
        !rdata_vld |-> (rdata == '0));
endmodule

// File: tb/tag_maint_port_tb.sv
module tag_maint_port_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wr_en, rd_en, xlat_miss, wb_ack;
    logic [31:0] addr, wdata;
    logic [31:0] rdata;
    logic        rdata_vld, wb_req;
    logic [1:0]  wb_way;
    logic [7:0]  wb_set;
    logic [21:0] wb_tag;

    int n_chk  = 0;
    int n_fail = 0;

    localparam logic [21:0] TA = 22'h2A5C3;
    localparam logic [21:0] TB = 22'h11111;
    localparam logic [21:0] TC = 22'h3F00F;
    localparam logic [21:0] TD = 22'h05A5A;

    always #4 clk = ~clk;

    tag_maint_port u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .xlat_miss(xlat_miss), .rdata(rdata), .rdata_vld(rdata_vld),
        .wb_req(wb_req), .wb_way(wb_way), .wb_set(wb_set), .wb_tag(wb_tag),
        .wb_ack(wb_ack)
    );

    function automatic logic [31:0] mk_a(input logic [7:0] rg, input logic assoc,
                                         input logic [1:0] way, input logic [7:0] set);
        return {rg, 9'd0, way, set, 1'b0, assoc, 3'b000};
    endfunction

    function automatic logic [31:0] mk_d(input logic [21:0] tag, input logic d, input logic v);
        return {tag, 8'd0, d, v};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] a, input logic [31:0] d, input logic miss);
        @(negedge clk);
        addr = a; wdata = d; xlat_miss = miss; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; xlat_miss = 1'b0;
    endtask

    task automatic rd(input logic [31:0] a, output logic [31:0] q, output logic v);
        @(negedge clk);
        addr = a; rd_en = 1'b1;
        @(negedge clk);
        q = rdata; v = rdata_vld; rd_en = 1'b0;
    endtask

    task automatic ack;
        @(negedge clk);
        wb_ack = 1'b1;
        @(negedge clk);
        wb_ack = 1'b0;
    endtask

    task automatic t_reset;
        logic [31:0] q; logic v;
        rd(mk_a(8'hF4, 1'b0, 2'd0, 8'd0), q, v);
        chk("R2 way0 set0 state bits", {62'd0, q[1:0]}, 64'd0);
        rd(mk_a(8'hF4, 1'b0, 2'd3, 8'd255), q, v);
        chk("R2 way3 set255 state bits", {62'd0, q[1:0]}, 64'd0);
        chk("R2 wb_req low", {63'd0, wb_req}, 64'd0);
    endtask

    task automatic t_direct;
        logic [31:0] q; logic v;
        wr(mk_a(8'hF4, 1'b0, 2'd2, 8'd15), mk_d(TA, 1'b1, 1'b1), 1'b0);
        rd(mk_a(8'hF4, 1'b0, 2'd2, 8'd15), q, v);
        chk("R3 direct write tag/dirty/valid", {32'd0, q}, {32'd0, mk_d(TA, 1'b1, 1'b1)});
        chk("R4 rdata_vld", {63'd0, v}, 64'd1);
        rd(mk_a(8'hF4, 1'b0, 2'd1, 8'd15), q, v);
        chk("R3 other way untouched", {62'd0, q[1:0]}, 64'd0);
    endtask

    task automatic t_region;
        logic [31:0] q; logic v;
        wr(mk_a(8'hF5, 1'b0, 2'd2, 8'd15), mk_d(TB, 1'b0, 1'b0), 1'b0);
        rd(mk_a(8'hF4, 1'b0, 2'd2, 8'd15), q, v);
        chk("R1 outside write ignored", {32'd0, q}, {32'd0, mk_d(TA, 1'b1, 1'b1)});
        rd(mk_a(8'hF5, 1'b0, 2'd2, 8'd15), q, v);
        chk("R1 outside read no valid", {63'd0, v}, 64'd0);
        chk("R1 outside read zero", {32'd0, q}, 64'd0);
    endtask

    task automatic t_assoc;
        logic [31:0] q; logic v;
        wr(mk_a(8'hF4, 1'b0, 2'd1, 8'd7), mk_d(TA, 1'b0, 1'b1), 1'b0);
        wr(mk_a(8'hF4, 1'b1, 2'd3, 8'd7), mk_d(TA, 1'b1, 1'b1), 1'b0);
        chk("R9 clean hit no request", {63'd0, wb_req}, 64'd0);
        rd(mk_a(8'hF4, 1'b0, 2'd1, 8'd7), q, v);
        chk("R5 assoc hit updates way1", {32'd0, q}, {32'd0, mk_d(TA, 1'b1, 1'b1)});
        rd(mk_a(8'hF4, 1'b0, 2'd3, 8'd7), q, v);
        chk("R5 way bits ignored", {62'd0, q[1:0]}, 64'd0);
    endtask

    task automatic t_nomatch;
        logic [31:0] q; logic v;
        wr(mk_a(8'hF4, 1'b1, 2'd1, 8'd7), mk_d(TB, 1'b0, 1'b0), 1'b0);
        rd(mk_a(8'hF4, 1'b0, 2'd1, 8'd7), q, v);
        chk("R6 tag mismatch no change", {32'd0, q}, {32'd0, mk_d(TA, 1'b1, 1'b1)});
        chk("R6 mismatch no request", {63'd0, wb_req}, 64'd0);
        wr(mk_a(8'hF4, 1'b0, 2'd0, 8'd9), mk_d(TC, 1'b0, 1'b0), 1'b0);
        wr(mk_a(8'hF4, 1'b1, 2'd0, 8'd9), mk_d(TC, 1'b1, 1'b1), 1'b0);
        rd(mk_a(8'hF4, 1'b0, 2'd0, 8'd9), q, v);
        chk("R6 invalid line not revived", {62'd0, q[1:0]}, 64'd0);
    endtask

    task automatic t_xlat;
        logic [31:0] q; logic v;
        wr(mk_a(8'hF4, 1'b1, 2'd0, 8'd7), mk_d(TA, 1'b0, 1'b0), 1'b1);
        chk("R7 translation miss no request", {63'd0, wb_req}, 64'd0);
        rd(mk_a(8'hF4, 1'b0, 2'd1, 8'd7), q, v);
        chk("R7 translation miss no change", {62'd0, q[1:0]}, 64'd3);
    endtask

    task automatic t_writeback;
        logic [31:0] q; logic v;
        wr(mk_a(8'hF4, 1'b1, 2'd0, 8'd7), mk_d(TA, 1'b0, 1'b1), 1'b0);
        chk("R8 clean of dirty line raises request", {63'd0, wb_req}, 64'd1);
        chk("R8 request fields", {32'd0, wb_way, wb_set, wb_tag}, {32'd0, 2'd1, 8'd7, TA});
        wr(mk_a(8'hF4, 1'b0, 2'd0, 8'd20), mk_d(TD, 1'b1, 1'b1), 1'b0);
        repeat (3) @(negedge clk);
        chk("R10 request held", {63'd0, wb_req}, 64'd1);
        chk("R10 fields held", {32'd0, wb_way, wb_set, wb_tag}, {32'd0, 2'd1, 8'd7, TA});
        rd(mk_a(8'hF4, 1'b0, 2'd1, 8'd7), q, v);
        chk("R8 line updated with request", {32'd0, q}, {32'd0, mk_d(TA, 1'b0, 1'b1)});
        ack();
        chk("R10 request drops after ack", {63'd0, wb_req}, 64'd0);
        rd(mk_a(8'hF4, 1'b0, 2'd0, 8'd20), q, v);
        chk("R11 write during pending ignored", {62'd0, q[1:0]}, 64'd0);
    endtask

    task automatic t_invalidate;
        logic [31:0] q; logic v;
        wr(mk_a(8'hF4, 1'b1, 2'd2, 8'd7), mk_d(TA, 1'b1, 1'b1), 1'b0);
        chk("R9 set dirty no request", {63'd0, wb_req}, 64'd0);
        wr(mk_a(8'hF4, 1'b1, 2'd2, 8'd7), mk_d(TA, 1'b1, 1'b0), 1'b0);
        chk("R8 invalidate dirty raises request", {63'd0, wb_req}, 64'd1);
        chk("R8 invalidate fields", {32'd0, wb_way, wb_set, wb_tag}, {32'd0, 2'd1, 8'd7, TA});
        ack();
        rd(mk_a(8'hF4, 1'b0, 2'd1, 8'd7), q, v);
        chk("R8 invalidated line state", {62'd0, q[1:0]}, 64'd2);
        wr(mk_a(8'hF4, 1'b0, 2'd3, 8'd40), mk_d(TB, 1'b1, 1'b1), 1'b0);
        wr(mk_a(8'hF4, 1'b1, 2'd0, 8'd40), mk_d(TB, 1'b1, 1'b1), 1'b0);
        chk("R9 dirty kept dirty no request", {63'd0, wb_req}, 64'd0);
    endtask

    task automatic t_multi;
        logic [31:0] q; logic v;
        wr(mk_a(8'hF4, 1'b0, 2'd2, 8'h33), mk_d(TC, 1'b0, 1'b1), 1'b0);
        wr(mk_a(8'hF4, 1'b0, 2'd3, 8'h33), mk_d(TC, 1'b0, 1'b1), 1'b0);
        wr(mk_a(8'hF4, 1'b1, 2'd0, 8'h33), mk_d(TC, 1'b1, 1'b1), 1'b0);
        rd(mk_a(8'hF4, 1'b0, 2'd2, 8'h33), q, v);
        chk("R12 lowest way updated", {62'd0, q[1:0]}, 64'd3);
        rd(mk_a(8'hF4, 1'b0, 2'd3, 8'h33), q, v);
        chk("R12 higher way untouched", {62'd0, q[1:0]}, 64'd1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; rd_en = 1'b0; xlat_miss = 1'b0; wb_ack = 1'b0;
        addr = '0; wdata = '0;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_direct();
        t_region();
        t_assoc();
        t_nomatch();
        t_xlat();
        t_writeback();
        t_invalidate();
        t_multi();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule